// File: doc/BRIEF.md
# Opposite-Edge Single-Clock FIFO

This block is a single-clock first-in first-out buffer arranged so that the storage is never written and read on the same clock edge. Writers and readers both work on the falling edge of `clk`. Read requests are served on that edge. A write request is captured on that edge into a retiming stage and enters the storage on the following rising edge, half a period later. The retiming sits only on the write side. A read therefore returns data on the edge that accepts it, and the empty flag follows accepted writes one user cycle later, the same as in a plain synchronous FIFO.

The fill level is tracked by a five-state machine in the falling-edge domain. The states are EMPTY (no words), LOW (1 to `AE_LVL` words), MID, HIGH (free space at or below `AF_GAP` but not zero) and FULL (`DEPTH` words). The level moves by at most one word per cycle. In the default configuration the transitions are EMPTY↔LOW, LOW↔MID, MID↔HIGH and HIGH↔FULL. A setting with a zero offset joins the neighbouring states directly. The flags are decoded from the state. There is deliberately no full output: writers stop on almost-full. A write that finds no room and a read that finds nothing stored are both dropped and reported by one-cycle error pulses. Readers should keep reading past almost-empty until empty asserts.

`AF_GAP` must be at least 2. That leaves room for a write that a registered writer has already issued when it sees almost-full. `AE_LVL` must be below `DEPTH - AF_GAP`.

Top module: `oe_fifo`

## Requirements
- R1: A synchronous reset, sampled on the falling edge, leaves empty = 1, almost_empty = 1, almost_full = 0, wr_err = 0, rd_err = 0 and rd_data = 0.
- R2: Words leave in the order they were accepted. rd_data takes the oldest stored word on the falling edge that accepts a read and holds its value on every edge without an accepted read.
- R3: empty is 1 exactly when the stored level is 0. After a write is accepted into an empty buffer, empty falls on that same falling edge.
- R4: almost_empty is 1 exactly when the stored level is at most `AE_LVL`, and this includes level 0.
- R5: almost_full is 1 exactly when `DEPTH` minus the stored level is at most `AF_GAP`.
- R6: A write requested while the level equals `DEPTH` is dropped, even when a read is accepted on the same edge. wr_err is 1 for that one cycle only.
- R7: A read requested while the level is 0 is dropped and leaves rd_data unchanged. rd_err is 1 for that one cycle only. A write on the same edge is still accepted.
- R8: A word accepted on one falling edge can be read on the next falling edge, even though it enters storage on the rising edge between them. A read and a write accepted on the same edge change the level by zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; user edge is falling, storage write edge is rising |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Most recently read word |
| empty | output | 1 | No word stored |
| almost_empty | output | 1 | Level at or below AE_LVL |
| almost_full | output | 1 | Free space at or below AF_GAP; write-stop signal |
| wr_err | output | 1 | One-cycle pulse: write dropped for lack of space |
| rd_err | output | 1 | One-cycle pulse: read dropped because empty |

## Verification
A write and a read can be accepted on the same falling edge. The hard cases are the empty boundary, where the read must be refused while the write lands, and the full boundary, where the write must be refused while the read frees a slot. Directed sequences fill the buffer to capacity and drain it, then request both operations together at each end. Constrained-random phases that bias toward filling, draining and balanced traffic then push the level through every state many times. A queue model in the bench decides each accept or drop, the expected word and every flag from the level before each edge.

// File: rtl/oe_fifo_pkg.sv
package oe_fifo_pkg;

    // Fill-level classes tracked on the user (falling) edge
    typedef enum logic [2:0] {
        LV_EMPTY = 3'd0,
        LV_LOW   = 3'd1,
        LV_MID   = 3'd2,
        LV_HIGH  = 3'd3,
        LV_FULL  = 3'd4
    } lvl_state_t;

    // Map a fill level onto its class
    function automatic lvl_state_t lvl_classify(
        input int unsigned level,
        input int unsigned depth,
        input int unsigned ae_lvl,
        input int unsigned af_gap
    );
        if (level == 0)
            return LV_EMPTY;
        else if (level >= depth)
            return LV_FULL;
        else if (depth - level <= af_gap)
            return LV_HIGH;
        else if (level <= ae_lvl)
            return LV_LOW;
        else
            return LV_MID;
    endfunction

endpackage

// File: rtl/oe_wr_stage.sv
// Retiming stage on the write side: captures an accepted write on the
// falling edge so the storage can take it on the following rising edge.
module oe_wr_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_acc,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wq_valid,
    output logic [DATA_W-1:0] wq_data
);

    always_ff @(negedge clk) begin
        if (rst) begin
            wq_valid <= 1'b0;
            wq_data  <= '0;
        end else begin
            wq_valid <= wr_acc;
            if (wr_acc)
                wq_data <= wr_data;
        end
    end

endmodule

// File: rtl/oe_store.sv
// Storage array: written on the rising edge, read on the falling edge.
module oe_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wq_valid,
    input  logic [DATA_W-1:0] wq_data,
    input  logic              rd_acc,
    output logic [DATA_W-1:0] rd_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Rising edge: commit the retimed write
    always_ff @(posedge clk) begin
        if (wq_valid)
            mem[wr_ptr] <= wq_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            wr_ptr <= '0;
        else if (wq_valid)
            wr_ptr <= ptr_inc(wr_ptr);
    end

    // Falling edge: serve the read with no added latency
    always_ff @(negedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            rd_data <= '0;
        end else if (rd_acc) begin
            rd_data <= mem[rd_ptr];
            rd_ptr  <= ptr_inc(rd_ptr);
        end
    end

endmodule

// File: rtl/oe_level_fsm.sv
// Fill-level state machine on the user (falling) edge. Decides which
// requests are accepted and decodes the flags from its state.
module oe_level_fsm
    import oe_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int AE_LVL = 3,
    parameter int AF_GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic rd_en,
    output logic wr_acc,
    output logic rd_acc,
    output logic empty,
    output logic almost_empty,
    output logic almost_full,
    output logic wr_err,
    output logic rd_err
);

    localparam int LW = $clog2(DEPTH + 1);

    lvl_state_t    state;
    lvl_state_t    state_nxt;
    logic [LW-1:0] level;
    logic [LW-1:0] level_nxt;

    // Acceptance depends only on the registered state
    assign wr_acc = wr_en && (state != LV_FULL);
    assign rd_acc = rd_en && (state != LV_EMPTY);

    always_comb begin
        level_nxt = level;
        if (wr_acc && !rd_acc)
            level_nxt = level + 1'b1;
        else if (rd_acc && !wr_acc)
            level_nxt = level - 1'b1;
        state_nxt = lvl_classify(int'(level_nxt), DEPTH, AE_LVL, AF_GAP);
    end

    // State register
    always_ff @(negedge clk) begin
        if (rst) begin
            state  <= LV_EMPTY;
            level  <= '0;
            wr_err <= 1'b0;
            rd_err <= 1'b0;
        end else begin
            state  <= state_nxt;
            level  <= level_nxt;
            wr_err <= wr_en && !wr_acc;
            rd_err <= rd_en && !rd_acc;
        end
    end

    // Flag decode
    always_comb begin
        empty        = 1'b0;
        almost_empty = 1'b0;
        almost_full  = 1'b0;
        unique case (state)
            LV_EMPTY: begin
                empty        = 1'b1;
                almost_empty = 1'b1;
            end
            LV_LOW:  almost_empty = 1'b1;
            LV_MID:  ;
            LV_HIGH: almost_full  = 1'b1;
            LV_FULL: almost_full  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/oe_fifo.sv
// Top: opposite-edge single-clock FIFO
module oe_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int AE_LVL = 3,
    parameter int AF_GAP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty,
    output logic              almost_full,
    output logic              wr_err,
    output logic              rd_err
);

    logic              wr_acc;
    logic              rd_acc;
    logic              wq_valid;
    logic [DATA_W-1:0] wq_data;

    oe_level_fsm #(
        .DEPTH (DEPTH),
        .AE_LVL(AE_LVL),
        .AF_GAP(AF_GAP)
    ) u_level (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wr_acc      (wr_acc),
        .rd_acc      (rd_acc),
        .empty       (empty),
        .almost_empty(almost_empty),
        .almost_full (almost_full),
        .wr_err      (wr_err),
        .rd_err      (rd_err)
    );

    oe_wr_stage #(
        .DATA_W(DATA_W)
    ) u_wstage (
        .clk     (clk),
        .rst     (rst),
        .wr_acc  (wr_acc),
        .wr_data (wr_data),
        .wq_valid(wq_valid),
        .wq_data (wq_data)
    );

    oe_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wq_valid(wq_valid),
        .wq_data (wq_data),
        .rd_acc  (rd_acc),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/oe_fifo_chk.sv
// Port-level checker, bound to every oe_fifo instance
module oe_fifo_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              empty,
    input logic              almost_empty,
    input logic              almost_full,
    input logic              wr_err,
    input logic              rd_err
);

    assert_empty_in_ae_R4: assert property (@(negedge clk) disable iff (rst)
        empty |-> almost_empty);

    assert_wr_err_cause_R6: assert property (@(negedge clk) disable iff (rst)
        wr_err |-> ($past(wr_en) && $past(almost_full)));

    assert_rd_err_cause_R7: assert property (@(negedge clk) disable iff (rst)
        rd_err |-> ($past(rd_en) && $past(empty)));

    assert_rd_hold_R2: assert property (@(negedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(rd_data));

    assert_empty_fall_R3: assert property (@(negedge clk) disable iff (rst)
        $fell(empty) |-> $past(wr_en));

    assert_err_excl_R7: assert property (@(negedge clk) disable iff (rst)
        !(wr_err && rd_err));

endmodule

bind oe_fifo oe_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .empty       (empty),
    .almost_empty(almost_empty),
    .almost_full (almost_full),
    .wr_err      (wr_err),
    .rd_err      (rd_err)
);

// File: tb/sim_oe_fifo.sv
module sim_oe_fifo;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 16;
    localparam int AE_LVL = 3;
    localparam int AF_GAP = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              empty, almost_empty, almost_full, wr_err, rd_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [DATA_W-1:0] model_q[$];
    logic [DATA_W-1:0] last_rd = '0;
    logic [DATA_W-1:0] seq_val = 16'h0100;

    always #4 clk = ~clk;  // 125 MHz

    oe_fifo #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_GAP(AF_GAP)
    ) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty),
        .almost_full(almost_full), .wr_err(wr_err), .rd_err(rd_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_ae(input int lvl);
        return lvl <= AE_LVL;
    endfunction

    function automatic bit exp_af(input int lvl);
        return (DEPTH - lvl) <= AF_GAP;
    endfunction

    // One user cycle: drive after the rising edge, let the falling edge act,
    // sample after the next rising edge, then compare with the model.
    task automatic step(input bit we, input bit re);
        int  lvl;
        bit  wacc, racc;
        wr_en   = we;
        rd_en   = re;
        wr_data = seq_val;
        lvl  = model_q.size();
        wacc = we && (lvl < DEPTH);
        racc = re && (lvl > 0);
        @(negedge clk);
        @(posedge clk);
        #1;
        if (racc) last_rd = model_q.pop_front();
        if (wacc) begin
            model_q.push_back(seq_val);
            seq_val = seq_val + 16'd1;
        end
        lvl = model_q.size();
        chk("R2 rd_data", 32'(rd_data), 32'(last_rd));
        chk("R3 empty", 32'(empty), 32'(lvl == 0));
        chk("R4 almost_empty", 32'(almost_empty), 32'(exp_ae(lvl)));
        chk("R5 almost_full", 32'(almost_full), 32'(exp_af(lvl)));
        chk("R6 wr_err", 32'(wr_err), 32'(we && !wacc));
        chk("R7 rd_err", 32'(rd_err), 32'(re && !racc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0e0f));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 almost_empty", 32'(almost_empty), 32'd1);
        chk("R1 almost_full", 32'(almost_full), 32'd0);
        chk("R1 wr_err", 32'(wr_err), 32'd0);
        chk("R1 rd_err", 32'(rd_err), 32'd0);
        chk("R1 rd_data", 32'(rd_data), 32'd0);

        // R7: read of an empty buffer, then read and write together
        step(0, 1);
        step(1, 1);
        // R8: word written last cycle is readable now
        step(0, 1);
        chk("R8 next-cycle read", 32'(rd_data), 32'h0100);

        // Fill to capacity, then push past it (R5, R6)
        for (int i = 0; i < DEPTH + 2; i++) step(1, 0);
        // R6: full with simultaneous read: write dropped, read served
        step(1, 1);
        chk("R6 level after drop", 32'(model_q.size()), 32'(DEPTH - 1));
        step(1, 1);  // R8: both accepted, level unchanged
        // Drain past empty (R2, R3, R4, R7)
        for (int i = 0; i < DEPTH + 2; i++) step(0, 1);
        step(1, 1);
        step(0, 0);

        // Constrained-random phases: fill, drain, balanced
        for (int ph = 0; ph < 30; ph++) begin
            int pw, pr;
            unique case (ph % 3)
                0: begin pw = 80; pr = 30; end
                1: begin pw = 25; pr = 80; end
                default: begin pw = 55; pr = 55; end
            endcase
            for (int c = 0; c < 120; c++)
                step(($urandom % 100) < pw, ($urandom % 100) < pr);
        end

        // Final drain
        for (int i = 0; i < DEPTH + 1; i++) step(0, 1);
        chk("R3 drained", 32'(empty), 32'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule